// File: doc/BRIEF.md
# Command Decoder and Bank State Tracker for a Bank-Grouped SDRAM

This block watches the command/address bus of a bank-grouped double-data-rate SDRAM, one sample per command clock. It classifies every cycle and keeps a record of which of the sixteen banks hold an open row and which row that is. Each decoded command is reported one clock later, with the fields that matter for that command. A dedicated active-low activate pin marks row opens. While that pin is low, the three strobe pins carry high-order row bits instead of a command code.

The block also applies the protocol's sequencing rules. It flags column accesses to closed banks, opens of banks that are already open, a refresh while any row is open, the one strobe combination that has no meaning, and any command to a bank whose burst has not finished. A burst shortened to four transfers still keeps its bank occupied for the full eight-transfer time, so the busy check does not depend on burst chop. A flag marks column accesses that stay in the same bank group as the previous accepted one, for use by a downstream timing checker. A flagged command never changes bank state.

Top module: `ddr4_cmd_tracker`

## Requirements
- R1: After reset, every bank is closed, `bank_open` is 0, `out_type` is 0 (deselect) and no error output is set.
- R2: All outputs are registered and reflect the command sampled on the previous rising clock edge. With `cs_n` high, the type is 0 (deselect) and bank state is untouched. With `cs_n` low and `act_n` high, {`ras_n`,`cas_n`,`we_n`} decodes as follows: 000 gives mode-register type 8, 001 gives refresh type 6, 010 gives precharge type 5, 100 gives write type 4, 101 gives read type 3, 110 gives ZQ type 7 and 111 gives no-op type 1.
- R3: With `cs_n` low and `act_n` low, the type is 2 (activate). The reported row is {`a17`,`ras_n`,`cas_n`,`we_n`,`addr`}. The bank index is {`bg`,`ba`} and that bank opens. An activate to an open bank sets `err_open` and changes nothing.
- R4: A read or write reports `out_col` = `addr[9:0]`, `out_ap` = `addr[10]`, `out_bc` = NOT `addr[12]`, and `out_row` = the row last activated in that bank (0 if none since reset). The same access to a closed bank sets `err_closed` and is ignored.
- R5: Precharge with `addr[10]` high sets `out_all` and closes all sixteen banks in one cycle. With `addr[10]` low it closes only bank {`bg`,`ba`}.
- R6: With `act_n` high, {`ras_n`,`cas_n`,`we_n`} = 011 reports type 9, sets `err_unused` and changes no state.
- R7: After an accepted read or write to a bank, the next BURST_CK-1 commands to that same bank (activate, read, write, precharge) set `err_busy` and are ignored. A precharge-all while any bank is busy is also flagged. Commands to other banks are accepted normally. Burst chop does not shorten this window.
- R8: An accepted access with auto-precharge clears that bank's `bank_open` bit on the BURST_CK-1'th clock edge after the access.
- R9: A refresh while any bank is open sets `err_open`. With all banks closed it is accepted.
- R10: A ZQ command reports `out_zq_long` = `addr[10]`.
- R11: `same_group` is 1 on a read or write whose `bg` equals the group of the most recent accepted read or write since reset. It is 0 on every other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate marker, active low |
| ras_n | input | 1 | Row strobe / row bit 16 |
| cas_n | input | 1 | Column strobe / row bit 15 |
| we_n | input | 1 | Write enable / row bit 14 |
| bg | input | 2 | Bank group |
| ba | input | 2 | Bank within group |
| a17 | input | 1 | Row bit 17 |
| addr | input | 14 | Address bits 13..0 |
| out_type | output | 4 | Decoded command code |
| out_bg | output | 2 | Reported bank group |
| out_ba | output | 2 | Reported bank |
| out_row | output | 18 | Row (activate or open row of accessed bank) |
| out_col | output | 10 | Column of read/write |
| out_ap | output | 1 | Auto-precharge requested |
| out_bc | output | 1 | Burst chop requested |
| out_all | output | 1 | Precharge targets all banks |
| out_zq_long | output | 1 | ZQ long variant |
| same_group | output | 1 | Access stays in the previous access's group |
| err_closed | output | 1 | Access to closed bank |
| err_open | output | 1 | Activate to open bank or refresh with open bank |
| err_busy | output | 1 | Command to a bank still bursting |
| err_unused | output | 1 | Unused strobe combination |
| bank_open | output | 16 | Open flag per bank, index {bg,ba} |

## Verification
The hardest state to reach is a busy window overlapping other activity. This means a chopped or auto-precharged burst still running while commands arrive for the same bank, for other banks in the same group, or as a precharge-all. Directed sequences place accesses on the exact edges just inside and just past the window's end. Random traffic is weighted toward activates and column accesses over a small set of banks, so that bursts overlap repeatedly. A bench-side model of open rows, busy counters and the last access group predicts every output.

// File: rtl/ddr4_cmd_tracker.sv
module ddr4_cmd_tracker #(
  parameter int BG_W     = 2,
  parameter int BA_W     = 2,
  parameter int ADDR_W   = 14,
  parameter int COL_W    = 10,
  parameter int BURST_CK = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      act_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [BG_W-1:0]           bg,
  input  logic [BA_W-1:0]           ba,
  input  logic                      a17,
  input  logic [ADDR_W-1:0]         addr,
  output logic [3:0]                out_type,
  output logic [BG_W-1:0]           out_bg,
  output logic [BA_W-1:0]           out_ba,
  output logic [ADDR_W+3:0]         out_row,
  output logic [COL_W-1:0]          out_col,
  output logic                      out_ap,
  output logic                      out_bc,
  output logic                      out_all,
  output logic                      out_zq_long,
  output logic                      same_group,
  output logic                      err_closed,
  output logic                      err_open,
  output logic                      err_busy,
  output logic                      err_unused,
  output logic [(1<<(BG_W+BA_W))-1:0] bank_open
);
  localparam int BK_W  = BG_W + BA_W;
  localparam int NB    = 1 << BK_W;
  localparam int ROW_W = ADDR_W + 4;
  localparam int CNT_W = $clog2(BURST_CK + 1);

  localparam logic [3:0] T_DES = 4'd0, T_NOP = 4'd1, T_ACT = 4'd2, T_RD  = 4'd3,
                         T_WR  = 4'd4, T_PRE = 4'd5, T_REF = 4'd6, T_ZQ  = 4'd7,
                         T_MRS = 4'd8, T_ILL = 4'd9;

  logic [CNT_W-1:0] cnt   [NB];
  logic [ROW_W-1:0] rows  [NB];
  logic [NB-1:0]    ap_q;
  logic [NB-1:0]    busy_v;
  logic [BG_W-1:0]  last_bg;
  logic             last_v;
  logic [3:0]       ty;

  wire [BK_W-1:0]  sel    = {bg, ba};
  wire [ROW_W-1:0] row_in = {a17, ras_n, cas_n, we_n, addr};

  always_comb begin
    if (cs_n)        ty = T_DES;
    else if (!act_n) ty = T_ACT;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b000:  ty = T_MRS;
        3'b001:  ty = T_REF;
        3'b010:  ty = T_PRE;
        3'b011:  ty = T_ILL;
        3'b100:  ty = T_WR;
        3'b101:  ty = T_RD;
        3'b110:  ty = T_ZQ;
        default: ty = T_NOP;
      endcase
    end
  end

  always_comb
    for (int i = 0; i < NB; i++) busy_v[i] = (cnt[i] != '0);

  wire is_acc   = (ty == T_RD) || (ty == T_WR);
  wire sel_open = bank_open[sel];
  wire sel_busy = busy_v[sel];
  wire any_open = |bank_open;
  wire any_busy = |busy_v;

  wire e_closed = is_acc && !sel_open;
  wire e_open   = ((ty == T_ACT) && sel_open) || ((ty == T_REF) && any_open);
  wire e_busy   = (((ty == T_ACT) || is_acc) && sel_busy) ||
                  ((ty == T_PRE) && (addr[10] ? any_busy : sel_busy));
  wire e_unused = (ty == T_ILL);
  wire ok       = !(e_closed || e_open || e_busy || e_unused);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_type    <= T_DES;
      out_bg      <= '0;
      out_ba      <= '0;
      out_row     <= '0;
      out_col     <= '0;
      out_ap      <= 1'b0;
      out_bc      <= 1'b0;
      out_all     <= 1'b0;
      out_zq_long <= 1'b0;
      same_group  <= 1'b0;
      err_closed  <= 1'b0;
      err_open    <= 1'b0;
      err_busy    <= 1'b0;
      err_unused  <= 1'b0;
      bank_open   <= '0;
      ap_q        <= '0;
      last_bg     <= '0;
      last_v      <= 1'b0;
      for (int i = 0; i < NB; i++) begin
        cnt[i]  <= '0;
        rows[i] <= '0;
      end
    end else begin
      out_type    <= ty;
      out_bg      <= cs_n ? '0 : bg;
      out_ba      <= cs_n ? '0 : ba;
      out_row     <= (ty == T_ACT) ? row_in : (is_acc ? rows[sel] : '0);
      out_col     <= is_acc ? addr[COL_W-1:0] : '0;
      out_ap      <= is_acc && addr[10];
      out_bc      <= is_acc && !addr[12];
      out_all     <= (ty == T_PRE) && addr[10];
      out_zq_long <= (ty == T_ZQ) && addr[10];
      same_group  <= is_acc && last_v && (bg == last_bg);
      err_closed  <= e_closed;
      err_open    <= e_open;
      err_busy    <= e_busy;
      err_unused  <= e_unused;

      for (int i = 0; i < NB; i++) begin
        if (busy_v[i]) begin
          cnt[i] <= cnt[i] - 1'b1;
          if (cnt[i] == CNT_W'(1) && ap_q[i]) bank_open[i] <= 1'b0;
        end
      end

      if (ok) begin
        case (ty)
          T_ACT: begin
            bank_open[sel] <= 1'b1;
            rows[sel]      <= row_in;
          end
          T_RD, T_WR: begin
            cnt[sel]  <= CNT_W'(BURST_CK - 1);
            ap_q[sel] <= addr[10];
            last_bg   <= bg;
            last_v    <= 1'b1;
          end
          T_PRE: begin
            if (addr[10]) bank_open <= '0;
            else          bank_open[sel] <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  wire out_err = err_closed || err_open || err_busy || err_unused;
  wire out_acc = ((out_type == T_RD) || (out_type == T_WR)) && !out_err;

  // R9
  refresh_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_type == T_REF && !err_open) |-> ($past(bank_open) == '0));

  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_type == T_ACT && !out_err) |-> bank_open[{out_bg, out_ba}]);

  // R5
  prea_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_type == T_PRE && out_all && !out_err) |-> (bank_open == '0));

  // R7
  busy_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_acc |=> !(out_acc && ({out_bg, out_ba} == $past({out_bg, out_ba}))));

  // R2
  des_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_type == T_DES && !$past(any_busy)) |-> (bank_open == $past(bank_open)));

  // R6
  unused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_unused && !$past(any_busy)) |-> (bank_open == $past(bank_open)));
endmodule

// File: tb/ddr4_cmd_tracker_bench.sv
module ddr4_cmd_tracker_bench;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, act_n = 1, ras_n = 1, cas_n = 1, we_n = 1, a17 = 0;
  logic [1:0] bg = 0, ba = 0;
  logic [13:0] addr = 0;
  logic [3:0] out_type;
  logic [1:0] out_bg, out_ba;
  logic [17:0] out_row;
  logic [9:0] out_col;
  logic out_ap, out_bc, out_all, out_zq_long, same_group;
  logic err_closed, err_open, err_busy, err_unused;
  logic [15:0] bank_open;

  ddr4_cmd_tracker u_ddr4_cmd_tracker (
    .clk, .rst_n, .cs_n, .act_n, .ras_n, .cas_n, .we_n, .bg, .ba, .a17, .addr,
    .out_type, .out_bg, .out_ba, .out_row, .out_col, .out_ap, .out_bc, .out_all,
    .out_zq_long, .same_group, .err_closed, .err_open, .err_busy, .err_unused,
    .bank_open);

  always #5 clk = ~clk;

  localparam int BCK = 4;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] m_open;
  logic [17:0] m_row [16];
  int          m_cnt [16];
  logic [15:0] m_ap;
  logic [1:0]  m_lbg;
  bit          m_lv;

  task automatic chk(bit cond, string req, longint act, longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] dec_type(logic c, logic a, logic r, logic ca, logic w);
    if (c) return 4'd0;
    if (!a) return 4'd2;
    case ({r, ca, w})
      3'b000: return 4'd8;
      3'b001: return 4'd6;
      3'b010: return 4'd5;
      3'b011: return 4'd9;
      3'b100: return 4'd4;
      3'b101: return 4'd3;
      3'b110: return 4'd7;
      default: return 4'd1;
    endcase
  endfunction

  task automatic step(logic c, logic a, logic r, logic ca, logic w,
                      logic [1:0] g, logic [1:0] b, logic hi, logic [13:0] ad);
    logic [3:0] t;
    int k;
    bit acc, anyo, anyb, ec, eo, eb, eu, ok, sg;
    logic [17:0] erow;
    t = dec_type(c, a, r, ca, w);
    k = {g, b};
    acc = (t == 3 || t == 4);
    anyo = (m_open != 0);
    anyb = 0;
    for (int i = 0; i < 16; i++) if (m_cnt[i] != 0) anyb = 1;
    ec = acc && !m_open[k];
    eo = (t == 2 && m_open[k]) || (t == 6 && anyo);
    eb = ((t == 2 || acc) && m_cnt[k] != 0) || (t == 5 && (ad[10] ? anyb : m_cnt[k] != 0));
    eu = (t == 9);
    ok = !(ec || eo || eb || eu);
    sg = acc && m_lv && (g == m_lbg);
    erow = (t == 2) ? {hi, r, ca, w, ad} : (acc ? m_row[k] : 18'd0);
    cs_n = c; act_n = a; ras_n = r; cas_n = ca; we_n = w; bg = g; ba = b; a17 = hi; addr = ad;
    @(posedge clk);
    @(negedge clk);
    chk(out_type == t, "R2 type", out_type, t);
    chk({out_bg, out_ba} == (c ? 4'd0 : {g, b}), "R2 bank", {out_bg, out_ba}, c ? 0 : {g, b});
    chk(out_row == erow, (t == 2) ? "R3 row" : "R4 row", out_row, erow);
    chk({out_col, out_ap, out_bc} == (acc ? {ad[9:0], ad[10], !ad[12]} : 12'd0),
        "R4 col/ap/bc", {out_col, out_ap, out_bc}, acc ? {ad[9:0], ad[10], !ad[12]} : 12'd0);
    chk(out_all == (t == 5 && ad[10]), "R5 all", out_all, t == 5 && ad[10]);
    chk(out_zq_long == (t == 7 && ad[10]), "R10 zq", out_zq_long, t == 7 && ad[10]);
    chk(same_group == sg, "R11 same_group", same_group, sg);
    chk(err_closed == ec, "R4 err_closed", err_closed, ec);
    chk(err_open == eo, "R3 R9 err_open", err_open, eo);
    chk(err_busy == eb, "R7 err_busy", err_busy, eb);
    chk(err_unused == eu, "R6 err_unused", err_unused, eu);
    for (int i = 0; i < 16; i++)
      if (m_cnt[i] != 0) begin
        if (m_cnt[i] == 1 && m_ap[i]) m_open[i] = 0;
        m_cnt[i]--;
      end
    if (ok) begin
      if (t == 2) begin m_open[k] = 1; m_row[k] = erow; end
      if (acc) begin m_cnt[k] = BCK - 1; m_ap[k] = ad[10]; m_lbg = g; m_lv = 1; end
      if (t == 5) begin if (ad[10]) m_open = 0; else m_open[k] = 0; end
    end
    chk(bank_open == m_open, "R8 R5 bank_open", bank_open, m_open);
  endtask

  task automatic act(logic [1:0] g, logic [1:0] b, logic [17:0] row);
    step(0, 0, row[16], row[15], row[14], g, b, row[17], row[13:0]);
  endtask
  task automatic rd(logic [1:0] g, logic [1:0] b, logic [13:0] ad);
    step(0, 1, 1, 0, 1, g, b, 0, ad);
  endtask
  task automatic wr(logic [1:0] g, logic [1:0] b, logic [13:0] ad);
    step(0, 1, 1, 0, 0, g, b, 0, ad);
  endtask
  task automatic nop();
    step(0, 1, 1, 1, 1, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    m_open = 0; m_ap = 0; m_lv = 0; m_lbg = 0;
    for (int i = 0; i < 16; i++) begin m_cnt[i] = 0; m_row[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(bank_open == 0 && out_type == 0, "R1 reset", {bank_open, out_type}, 0);
    chk(!(err_closed || err_open || err_busy || err_unused), "R1 errors", 1, 0);

    // R3 activate row mapping, R4 chopped read, R7 window
    act(1, 1, 18'h2ABCD);
    act(0, 2, 18'h1F00F);
    rd(1, 1, 14'h0123);            // chop (A12 low)
    rd(1, 1, 14'h1005);            // R7 busy
    rd(0, 2, 14'h1044);            // other bank same cycle window, R11 differs group
    act(1, 1, 18'h00001);          // R7 busy and R3 open
    rd(1, 1, 14'h1000);            // accepted after window
    wr(1, 0, 14'h0000);            // R4 closed bank
    // R8 auto-precharge closing edge
    wr(0, 2, 14'h1400);
    nop(); nop(); nop(); nop();
    // R6 unused code, R9 refresh with open bank then closed
    step(0, 1, 0, 1, 1, 2, 3, 0, 0);
    step(0, 1, 0, 0, 1, 0, 0, 0, 0);
    step(0, 1, 0, 1, 0, 0, 0, 0, 14'h0400); // R5 precharge all
    step(0, 1, 0, 0, 1, 0, 0, 0, 0);        // R9 refresh accepted
    step(0, 1, 1, 1, 0, 0, 0, 0, 14'h0400); // R10 long
    step(0, 1, 1, 1, 0, 0, 0, 0, 14'h0000); // R10 short
    step(1, 0, 0, 0, 0, 3, 3, 1, 14'h3FFF); // R2 deselect
    // R5 precharge-all while busy
    act(2, 2, 18'h3FFFF);
    rd(2, 2, 14'h0000);
    step(0, 1, 0, 1, 0, 0, 0, 0, 14'h0400);
    step(0, 1, 0, 1, 0, 2, 2, 0, 14'h0000);

    seed = 32'h1234;
    void'($urandom(seed));
    for (int n = 0; n < 3000; n++) begin
      int sel;
      logic [1:0] g, b;
      logic [17:0] rv;
      logic [13:0] av;
      sel = $urandom % 100;
      g = $urandom % 4;
      b = ($urandom % 2) ? 2'd0 : ($urandom % 4);
      rv = $urandom;
      av = $urandom;
      if (sel < 25) act(g, b, rv);
      else if (sel < 45) rd(g, b, av);
      else if (sel < 60) wr(g, b, av);
      else if (sel < 72) step(0, 1, 0, 1, 0, g, b, 0, av);
      else if (sel < 76) step(0, 1, 0, 0, 1, g, b, 0, av);
      else if (sel < 80) step(0, 1, 1, 1, 0, g, b, 0, av);
      else if (sel < 84) step(0, 1, 0, 0, 0, g, b, 0, av);
      else if (sel < 87) step(0, 1, 0, 1, 1, g, b, 0, av);
      else if (sel < 93) step(1, $urandom, $urandom, $urandom, $urandom, g, b, rv[17], av);
      else nop();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule